// File: doc/BRIEF.md
# Remote Terminal Command Address Filter

This block sits behind the word decoder of a command/response serial-bus remote terminal. The receiver hands it a 16-bit command word and a one-cycle strobe. The terminal's own address comes from five strap pins and one parity strap. The filter decides whether the terminal must answer the command. It also marks commands sent to all terminals and commands that carry a mode code. For an accepted command, it captures the direction bit, the subaddress and the count/mode-code field and holds them steady for the subsystem.

The strap parity is checked continuously. A bad strap set raises an active-low error flag. While the flag is raised, commands addressed to this terminal alone are refused, but commands sent to all terminals still get through when that feature is enabled. Outputs are registered. Results for a strobe appear on the first clock edge after the strobe edge, and they are held until the next strobe.

Top module: `rt_cmd_filter`

## Requirements
- R1: `addr_err_n_o` is driven from the straps sampled on the previous clock edge. It is 1 when the five address straps plus the parity strap contain an odd number of ones, and 0 otherwise.
- R2: A strobed command whose address field (bits 15:11) equals the strap address, with good strap parity, sets `resp_o`=1 and `bcast_o`=0 after the next edge, unless it is a broadcast as defined in R4.
- R3: When the strap parity is bad, a strobed command whose address matches the straps is refused (`resp_o`=0), unless it is a broadcast as defined in R4.
- R4: With `bcast_en`=1, a strobed command with address 31 (all ones) gives `resp_o`=1 and `bcast_o`=1. This holds whatever the strap address and the strap parity are.
- R5: With `bcast_en`=0, address 31 is answered only when the straps are set to 31 with good parity, and then `bcast_o`=0.
- R6: `mode_o`=1 after an accepted command whose subaddress field (bits 9:5) is all zeros or all ones. For any other accepted command, `mode_o`=0.
- R7: On an accepted strobe, the outputs load from the command fields: `lat_tr_o` from bit 10, `lat_sub_o` from bits 9:5 and `lat_cnt_o` from bits 4:0.
- R8: A strobed command that is not accepted clears `resp_o`, `bcast_o` and `mode_o`, and leaves the three field outputs unchanged.
- R9: In a cycle without a strobe, `resp_o`, `bcast_o`, `mode_o` and the field outputs keep their values, whatever `cmd_word` holds.
- R10: A synchronous active-low reset clears `resp_o`, `bcast_o`, `mode_o` and all field outputs to 0, and sets `addr_err_n_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_word | input | 16 | Decoded command word |
| cmd_stb | input | 1 | One-cycle strobe marking a valid command word |
| strap_addr | input | 5 | Strapped terminal address |
| strap_par | input | 1 | Strap parity bit (odd parity with strap_addr) |
| bcast_en | input | 1 | Enables address 31 as all-terminal address |
| resp_o | output | 1 | Last strobed command must be answered |
| bcast_o | output | 1 | Last accepted command was a broadcast |
| mode_o | output | 1 | Last accepted command was a mode command |
| lat_tr_o | output | 1 | Held direction bit |
| lat_sub_o | output | 5 | Held subaddress field |
| lat_cnt_o | output | 5 | Held word count / mode code field |
| addr_err_n_o | output | 1 | Strap parity error, active low |

## Verification
Two overlaps are the hardest to reach from the ports. The first is a broadcast arriving while the straps carry a parity error. The second is straps set to 31 while broadcast is disabled, so that address 31 has to be treated as a unicast match. Uniformly random command words almost never hit these cases, so the stimulus biases the address field towards the strap value and towards 31, and it keeps flipping the parity strap and the broadcast enable. The random run also moves the straps onto 31 part of the time, and directed steps visit each of these corners explicitly before the random run.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
  localparam int FLD_W   = 5;
  localparam int CMD_W   = 3 * FLD_W + 1;
  localparam int CNT_LSB = 0;
  localparam int SUB_LSB = CNT_LSB + FLD_W;
  localparam int TR_BIT  = SUB_LSB + FLD_W;
  localparam int ADR_LSB = TR_BIT + 1;

  typedef struct packed {
    logic [FLD_W-1:0] addr;
    logic             tr;
    logic [FLD_W-1:0] sub;
    logic [FLD_W-1:0] cnt;
  } cmd_t;

  function automatic cmd_t split_cmd(input logic [CMD_W-1:0] w);
    return cmd_t'(w);
  endfunction

  // odd number of ones across address straps and parity strap
  function automatic logic strap_good(input logic [FLD_W-1:0] a, input logic p);
    return ^{a, p};
  endfunction

  // field is all zeros or all ones
  function automatic logic uniform_field(input logic [FLD_W-1:0] f);
    return (f == '0) || (&f);
  endfunction
endpackage

// File: rtl/rtf_strap_check.sv
module rtf_strap_check
  import rtf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLD_W-1:0] strap_addr,
  input  logic             strap_par,
  output logic             ok_o,
  output logic             err_n_o
);
  assign ok_o = strap_good(strap_addr, strap_par);

  always_ff @(posedge clk) begin
    if (!rst_n) err_n_o <= 1'b1;
    else        err_n_o <= ok_o;
  end
endmodule

// File: rtl/rtf_decode.sv
module rtf_decode
  import rtf_pkg::*;
(
  input  logic [FLD_W-1:0] cmd_addr,
  input  logic [FLD_W-1:0] cmd_sub,
  input  logic [FLD_W-1:0] strap_addr,
  input  logic             strap_ok,
  input  logic             bcast_en,
  output logic             accept_o,
  output logic             bcast_o,
  output logic             mode_o
);
  logic all_ones, own_hit, bc_hit;

  always_comb begin
    all_ones = &cmd_addr;
    bc_hit   = bcast_en && all_ones;
    own_hit  = (cmd_addr == strap_addr) && !bc_hit && strap_ok;
    accept_o = bc_hit || own_hit;
    bcast_o  = bc_hit;
    mode_o   = accept_o && uniform_field(cmd_sub);
  end
endmodule

// File: rtl/rtf_field_latch.sv
module rtf_field_latch
  import rtf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             accept,
  input  logic             bcast,
  input  logic             mode,
  input  logic             tr,
  input  logic [FLD_W-1:0] sub,
  input  logic [FLD_W-1:0] cnt,
  output logic             resp_o,
  output logic             bcast_o,
  output logic             mode_o,
  output logic             tr_o,
  output logic [FLD_W-1:0] sub_o,
  output logic [FLD_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_o  <= 1'b0;
      bcast_o <= 1'b0;
      mode_o  <= 1'b0;
      tr_o    <= 1'b0;
      sub_o   <= '0;
      cnt_o   <= '0;
    end else if (stb) begin
      resp_o  <= accept;
      bcast_o <= bcast;
      mode_o  <= mode;
      if (accept) begin
        tr_o  <= tr;
        sub_o <= sub;
        cnt_o <= cnt;
      end
    end
  end
endmodule

// File: rtl/rt_cmd_filter.sv
module rt_cmd_filter
  import rtf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             cmd_stb,
  input  logic [FLD_W-1:0] strap_addr,
  input  logic             strap_par,
  input  logic             bcast_en,
  output logic             resp_o,
  output logic             bcast_o,
  output logic             mode_o,
  output logic             lat_tr_o,
  output logic [FLD_W-1:0] lat_sub_o,
  output logic [FLD_W-1:0] lat_cnt_o,
  output logic             addr_err_n_o
);
  cmd_t w_cmd;
  logic w_strap_ok, w_accept, w_bcast, w_mode;

  assign w_cmd = split_cmd(cmd_word);

  rtf_strap_check u_strap (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_addr (strap_addr),
    .strap_par  (strap_par),
    .ok_o       (w_strap_ok),
    .err_n_o    (addr_err_n_o)
  );

  rtf_decode u_dec (
    .cmd_addr   (w_cmd.addr),
    .cmd_sub    (w_cmd.sub),
    .strap_addr (strap_addr),
    .strap_ok   (w_strap_ok),
    .bcast_en   (bcast_en),
    .accept_o   (w_accept),
    .bcast_o    (w_bcast),
    .mode_o     (w_mode)
  );

  rtf_field_latch u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (cmd_stb),
    .accept  (w_accept),
    .bcast   (w_bcast),
    .mode    (w_mode),
    .tr      (w_cmd.tr),
    .sub     (w_cmd.sub),
    .cnt     (w_cmd.cnt),
    .resp_o  (resp_o),
    .bcast_o (bcast_o),
    .mode_o  (mode_o),
    .tr_o    (lat_tr_o),
    .sub_o   (lat_sub_o),
    .cnt_o   (lat_cnt_o)
  );
endmodule

// File: rtl/rt_cmd_filter_chk.sv
module rt_cmd_filter_chk
  import rtf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CMD_W-1:0] cmd_word,
  input logic             cmd_stb,
  input logic [FLD_W-1:0] strap_addr,
  input logic             strap_par,
  input logic             bcast_en,
  input logic             resp_o,
  input logic             bcast_o,
  input logic             mode_o,
  input logic             lat_tr_o,
  input logic [FLD_W-1:0] lat_sub_o,
  input logic [FLD_W-1:0] lat_cnt_o,
  input logic             addr_err_n_o,
  input logic             w_strap_ok,
  input logic             w_accept
);
  logic to_all;
  assign to_all = &cmd_word[ADR_LSB +: FLD_W];

  assert_strap_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> addr_err_n_o == (^{$past(strap_addr), $past(strap_par)}));

  assert_bad_strap_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb && !w_strap_ok && !(bcast_en && to_all) |=> !resp_o);

  assert_bcast_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb && bcast_en && to_all |=> resp_o && bcast_o);

  assert_addr31_no_bcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb && !bcast_en && to_all && !(&strap_addr) |=> !resp_o && !bcast_o);

  assert_mode_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o |-> resp_o && (lat_sub_o == '0 || &lat_sub_o));

  assert_fields_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb && w_accept |=> lat_tr_o == $past(cmd_word[TR_BIT])
      && lat_sub_o == $past(cmd_word[SUB_LSB +: FLD_W])
      && lat_cnt_o == $past(cmd_word[CNT_LSB +: FLD_W]));

  assert_reject_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb && !w_accept |=> !resp_o && $stable(lat_sub_o) && $stable(lat_cnt_o));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |=> $stable(resp_o) && $stable(bcast_o) && $stable(mode_o)
      && $stable(lat_tr_o) && $stable(lat_sub_o));
endmodule

bind rt_cmd_filter rt_cmd_filter_chk u_chk (.*);

// File: tb/sim_rt_cmd_filter.sv
module sim_rt_cmd_filter;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        cmd_stb = 1'b0;
  logic [4:0]  strap_addr = '0;
  logic        strap_par = 1'b1;
  logic        bcast_en = 1'b0;
  logic        resp_o, bcast_o, mode_o, lat_tr_o, addr_err_n_o;
  logic [4:0]  lat_sub_o, lat_cnt_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0, cmp_en = 0;

  // reference state
  int m_resp, m_bc, m_mode, m_tr, m_sub, m_cnt, m_err;

  always #(CLK_P/2) clk = ~clk;

  rt_cmd_filter u0 (.*);

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < 6; i++) c += (v >> i) & 1;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_resp = 0; m_bc = 0; m_mode = 0; m_tr = 0; m_sub = 0; m_cnt = 0; m_err = 1;
    end else begin
      int a, s, acc, b, good;
      good  = ones({strap_par, strap_addr}) % 2;
      m_err = good;
      if (cmd_stb) begin
        a   = cmd_word / 2048;
        s   = (cmd_word / 32) % 32;
        b   = (bcast_en && a == 31) ? 1 : 0;
        acc = (b || (a == strap_addr && good)) ? 1 : 0;
        m_resp = acc;
        m_bc   = b;
        m_mode = (acc && (s == 0 || s == 31)) ? 1 : 0;
        if (acc) begin
          m_tr  = (cmd_word / 1024) % 2;
          m_sub = s;
          m_cnt = cmd_word % 32;
        end
      end
    end
  end

  task automatic expect_eq(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) if (cmp_en && !done) begin
    expect_eq("R1 addr_err_n_o", addr_err_n_o, m_err);
    expect_eq("R2 resp_o", resp_o, m_resp);
    expect_eq("R4 bcast_o", bcast_o, m_bc);
    expect_eq("R6 mode_o", mode_o, m_mode);
    expect_eq("R7 lat_tr_o", lat_tr_o, m_tr);
    expect_eq("R7 lat_sub_o", lat_sub_o, m_sub);
    expect_eq("R7 lat_cnt_o", lat_cnt_o, m_cnt);
  end

  function automatic logic [15:0] mk(input int a, input int tr, input int s, input int c);
    return {a[4:0], tr[0], s[4:0], c[4:0]};
  endfunction

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_word = w; cmd_stb = 1'b1;
    @(negedge clk);
    cmd_stb = 1'b0;
    #1;
  endtask

  task automatic straps(input int a, input int p, input int be);
    @(negedge clk);
    strap_addr = a[4:0]; strap_par = p[0]; bcast_en = be[0];
    @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    cmp_en = 1;
    @(negedge clk); #1;
    // R10: reset state
    expect_eq("R10 resp_o", resp_o, 0);
    expect_eq("R10 lat_sub_o", lat_sub_o, 0);
    expect_eq("R10 addr_err_n_o", addr_err_n_o, 1);
    rst_n = 1'b1;
    straps(5, 1, 0);                       // 00101 + 1 -> odd
    expect_eq("R1 good straps", addr_err_n_o, 1);
    send(mk(5, 1, 3, 7));                  // R2, R7
    expect_eq("R2 resp", resp_o, 1);
    expect_eq("R2 bcast", bcast_o, 0);
    expect_eq("R7 sub", lat_sub_o, 3);
    expect_eq("R7 cnt", lat_cnt_o, 7);
    expect_eq("R7 tr", lat_tr_o, 1);
    @(negedge clk); cmd_word = mk(9, 0, 12, 1);   // R9: no strobe
    @(negedge clk); #1;
    expect_eq("R9 hold sub", lat_sub_o, 3);
    expect_eq("R9 hold resp", resp_o, 1);
    send(mk(6, 0, 9, 9));                  // R8: foreign address
    expect_eq("R8 resp", resp_o, 0);
    expect_eq("R8 sub kept", lat_sub_o, 3);
    send(mk(5, 0, 0, 2));                  // R6
    expect_eq("R6 sub zero", mode_o, 1);
    send(mk(5, 1, 31, 4));
    expect_eq("R6 sub ones", mode_o, 1);
    send(mk(5, 1, 30, 4));
    expect_eq("R6 normal", mode_o, 0);
    straps(5, 0, 0);                       // R1/R3: bad parity
    expect_eq("R1 bad straps", addr_err_n_o, 0);
    send(mk(5, 0, 4, 4));
    expect_eq("R3 refused", resp_o, 0);
    expect_eq("R3 sub kept", lat_sub_o, 30);
    straps(5, 0, 1);                       // R4 under strap error
    send(mk(31, 0, 8, 6));
    expect_eq("R4 resp", resp_o, 1);
    expect_eq("R4 bcast", bcast_o, 1);
    straps(5, 1, 0);                       // R5
    send(mk(31, 0, 8, 6));
    expect_eq("R5 not own", resp_o, 0);
    straps(31, 0, 0);
    send(mk(31, 1, 2, 3));
    expect_eq("R5 own 31", resp_o, 1);
    expect_eq("R5 own 31 bcast", bcast_o, 0);
    straps(31, 0, 1);
    send(mk(31, 1, 2, 3));
    expect_eq("R4 strap 31", bcast_o, 1);
    @(negedge clk); rst_n = 1'b0;          // R10 mid-run
    @(negedge clk); #1;
    expect_eq("R10 resp cleared", resp_o, 0);
    expect_eq("R10 tr cleared", lat_tr_o, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4000; k++) begin
      int a, pick;
      @(negedge clk);
      if (k % 97 == 0) begin
        strap_addr = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom);
        strap_par  = 1'($urandom);
        bcast_en   = 1'($urandom);
      end
      pick = $urandom % 4;
      a = (pick == 0) ? 31 : (pick == 1) ? $urandom % 32 : strap_addr;
      cmd_word = mk(a, $urandom, ($urandom % 3 == 0) ? 0 : $urandom, $urandom);
      cmd_stb  = ($urandom % 3 != 0);
      rst_n    = ($urandom % 500 != 0);
    end
    @(negedge clk); cmd_stb = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1..R10 actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule